// File: doc/BRIEF.md
# Chained Transmit Descriptor DMA Engine

This block fetches transmit work from a chain of four-word descriptors kept in a word-addressed memory and turns it into a byte stream toward a MAC. A descriptor holds four words:
- word 0: ownership and status
- word 1: control, with the frame length
- word 2: the word address of the frame buffer
- word 3: the word address of the next descriptor

Software links the last descriptor back to the first, which closes the ring. When the engine owns a descriptor, it reads the buffer one word at a time and sends the bytes. It then writes a status word over word 0, which hands the descriptor back to software, and moves on to the descriptor named by word 3.

If the engine reads a descriptor it does not own, it stops on that descriptor and reports itself suspended. It stays there until software writes a poll demand, and then it reads the same descriptor again. Software sets the descriptor address through a small write port, and may do so only while the engine is at rest. The MAC reports per-byte fault flags. The engine gathers them across the frame into the written-back status word. It also raises a one-cycle completion pulse, together with an interrupt qualifier when the descriptor requested one.

Top module: `txd_ring_dma`

## Requirements
- R1: After reset the engine is idle: no memory read or write, `tx_valid`, `cmpl_pulse` and `suspended` low. It stays idle until a poll demand.
- R2: While idle or suspended:
  - a write with `cfg_sel`=0 loads `cfg_wdata` as the current descriptor address;
  - a write with `cfg_sel`=1 and `cfg_wdata[0]`=1 starts a fetch at the current descriptor;
  - a poll write with `cfg_wdata[0]`=0 is ignored.
  
  While the engine is busy, address writes are ignored.
- R3: Word 0 bit 31 set means the engine owns the descriptor. On a descriptor it does not own, the engine raises `suspended`, sends no bytes and writes nothing. It keeps the current address, so a later poll demand re-reads that same descriptor.
- R4: For an owned descriptor, the engine sends the number of bytes given by word 1 bits 10:0 from the buffer at the word address in word 2. Within each buffer word, byte 0 (bits 7:0) goes first. `tx_last` marks the final byte of the frame.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` stay unchanged and `tx_valid` stays high.
- R6: After the frame, word 0 of the same descriptor is rewritten with bit 31 clear. `mac_fault` bits are ORed only over accepted bytes:
  - `mac_fault[0]` goes to status bit 1;
  - `mac_fault[1]` goes to status bit 8;
  - `mac_fault[2]` goes to status bit 9;
  - `mac_fault[3]` goes to status bit 14.
  
  Bit 15 is the OR of bits 1, 8, 9 and 14 (mask 0x4302). All other status bits are 0.
- R7: `cmpl_pulse` is high for exactly the one cycle after each status write. `cmpl_irq` is high in that same cycle only when word 1 bit 31 is set.
- R8: After completion, the engine continues at the address in word 3, so a closed ring wraps back to its first descriptor.
- R9: A descriptor with length 0 sends no bytes, gets status 0x00000000 written back, and completes.
- R10: A descriptor with length above 1514 sends no bytes and gets status 0x0000C000 written back (bits 14 and 15).
- R11: Word 1 bits 30:11 have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: descriptor address, 1: poll demand |
| cfg_wdata | input | 32 | Register write data |
| mem_rd | output | 1 | Memory read request; data is returned on the next cycle |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data (status word) |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd` |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| mac_fault | input | 4 | Per-byte fault flags: underflow, excessive collision, late collision, jabber |
| cmpl_pulse | output | 1 | One-cycle completion pulse |
| cmpl_irq | output | 1 | Completion for a descriptor that requested an interrupt |
| suspended | output | 1 | Engine stopped on a descriptor it does not own |

## Verification
The bench checks frame lengths of 1 to 5 bytes, which find byte-lane and chunk-count errors. A wrong design would repeat or drop the bytes of a partial last word, or mark `tx_last` in the wrong place. Zero-length and oversize descriptors are mixed into a ring: a design that streams them anyway, or skips their write-back, breaks the byte count or leaves a stale status word. The bench applies random backpressure and drives garbage fault flags on stalled cycles, which exposes a design that changes data during a stall or samples faults on bytes that were not accepted. Finally the ring wraps onto a descriptor that has already been returned. The engine must suspend there, and after a re-poll it must restart on that same descriptor without touching the next one. A design that advanced the address would be caught.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
  localparam int LEN_W   = 11;
  localparam int OWN_BIT = 31;
  localparam int IRQ_BIT = 31;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SUSP, ST_RDW, ST_LAW, ST_BRD, ST_BLA, ST_STR, ST_WB, ST_CMP
  } txd_state_e;

  typedef struct packed {
    logic jabber;
    logic late_col;
    logic exc_col;
    logic underflow;
  } txd_fault_t;

  function automatic logic [31:0] pack_status(input txd_fault_t f);
    logic [31:0] s;
    s     = '0;
    s[1]  = f.underflow;
    s[8]  = f.exc_col;
    s[9]  = f.late_col;
    s[14] = f.jabber;
    s[15] = |f;
    return s;
  endfunction

  function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] i);
    return w[8*i +: 8];
  endfunction

  function automatic logic [2:0] chunk_len(input logic [LEN_W-1:0] rem);
    return (rem >= LEN_W'(4)) ? 3'd4 : rem[2:0];
  endfunction
endpackage

// File: rtl/txd_byte_ser.sv
`timescale 1ns/1ps
module txd_byte_ser import txd_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] ld_word,
  input  logic [2:0]  ld_cnt,
  input  logic        ld_final,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        take,
  output logic        chunk_end
);
  logic [31:0] word_q;
  logic [1:0]  idx_q;
  logic [2:0]  cnt_q;
  logic        final_q;
  logic        busy_q;
  logic        at_end;

  assign at_end    = ({1'b0, idx_q} == (cnt_q - 3'd1));
  assign tx_valid  = busy_q;
  assign tx_data   = byte_of(word_q, idx_q);
  assign tx_last   = busy_q && final_q && at_end;
  assign take      = busy_q && tx_ready;
  assign chunk_end = take && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      final_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (load) begin
      word_q  <= ld_word;
      cnt_q   <= ld_cnt;
      final_q <= ld_final;
      idx_q   <= '0;
      busy_q  <= 1'b1;
    end else if (take) begin
      if (at_end) busy_q <= 1'b0;
      else        idx_q  <= idx_q + 2'd1;
    end
  end
endmodule

// File: rtl/txd_fault_acc.sv
`timescale 1ns/1ps
module txd_fault_acc import txd_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        take,
  input  logic [3:0]  fault_in,
  input  logic        set_ovs,
  output logic [31:0] status_word
);
  txd_fault_t acc_q;
  txd_fault_t add_c;

  always_comb begin
    add_c = '0;
    if (take)    add_c = txd_fault_t'(fault_in);
    if (set_ovs) add_c.jabber = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= acc_q | add_c;
  end

  assign status_word = pack_status(acc_q);
endmodule

// File: rtl/txd_ring_dma.sv
`timescale 1ns/1ps
module txd_ring_dma import txd_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int MAX_FRAME = 1514
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic [3:0]        mac_fault,
  output logic              cmpl_pulse,
  output logic              cmpl_irq,
  output logic              suspended
);
  typedef logic [ADDR_W-1:0] addr_t;
  localparam logic [LEN_W-1:0] MAX_LEN    = LEN_W'(MAX_FRAME);
  localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

  txd_state_e       state_q;
  logic [1:0]       wi_q;
  addr_t            cur_q, buf_q, nxt_q, boff_q;
  logic             ic_q;
  logic [LEN_W-1:0] len_q, rem_q;

  logic        at_rest, base_wr, poll_wr;
  logic        ev_latch, ev_not_owned, ev_desc_owned, ev_skip, ev_oversize;
  logic        ev_last_chunk, ser_load, ser_take, ser_chunk_end;
  logic [31:0] status_word;
  logic        unused_bits;

  assign unused_bits = ^{cfg_wdata[31:ADDR_W], mem_rdata[30:ADDR_W]};

  assign at_rest       = (state_q == ST_IDLE) || (state_q == ST_SUSP);
  assign base_wr       = cfg_wr && !cfg_sel && at_rest;
  assign poll_wr       = cfg_wr && cfg_sel && cfg_wdata[0] && at_rest;
  assign ev_latch      = (state_q == ST_LAW);
  assign ev_not_owned  = ev_latch && (wi_q == 2'd0) && !mem_rdata[OWN_BIT];
  assign ev_desc_owned = ev_latch && (wi_q == 2'd0) &&  mem_rdata[OWN_BIT];
  assign ev_oversize   = ev_latch && (wi_q == 2'd3) && (len_q > MAX_LEN);
  assign ev_skip       = ev_latch && (wi_q == 2'd3) && ((len_q == '0) || (len_q > MAX_LEN));
  assign ev_last_chunk = ser_chunk_end && (rem_q <= WORD_BYTES);
  assign ser_load      = (state_q == ST_BLA);

  txd_byte_ser u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ser_load),
    .ld_word   (mem_rdata),
    .ld_cnt    (chunk_len(rem_q)),
    .ld_final  (rem_q <= WORD_BYTES),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .take      (ser_take),
    .chunk_end (ser_chunk_end)
  );

  txd_fault_acc u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (ev_desc_owned),
    .take        (ser_take),
    .fault_in    (mac_fault),
    .set_ovs     (ev_oversize),
    .status_word (status_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wi_q    <= '0;
      cur_q   <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      boff_q  <= '0;
      ic_q    <= 1'b0;
      len_q   <= '0;
      rem_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_SUSP: begin
          if (base_wr) begin
            cur_q <= cfg_wdata[ADDR_W-1:0];
          end else if (poll_wr) begin
            wi_q    <= 2'd0;
            state_q <= ST_RDW;
          end
        end
        ST_RDW: state_q <= ST_LAW;
        ST_LAW: begin
          case (wi_q)
            2'd0: begin
              if (ev_not_owned) begin
                state_q <= ST_SUSP;
              end else begin
                wi_q    <= 2'd1;
                state_q <= ST_RDW;
              end
            end
            2'd1: begin
              ic_q    <= mem_rdata[IRQ_BIT];
              len_q   <= mem_rdata[LEN_W-1:0];
              wi_q    <= 2'd2;
              state_q <= ST_RDW;
            end
            2'd2: begin
              buf_q   <= mem_rdata[ADDR_W-1:0];
              wi_q    <= 2'd3;
              state_q <= ST_RDW;
            end
            2'd3: begin
              nxt_q   <= mem_rdata[ADDR_W-1:0];
              rem_q   <= len_q;
              boff_q  <= '0;
              state_q <= ev_skip ? ST_WB : ST_BRD;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
        ST_BRD: state_q <= ST_BLA;
        ST_BLA: state_q <= ST_STR;
        ST_STR: begin
          if (ser_chunk_end) begin
            rem_q <= rem_q - LEN_W'(chunk_len(rem_q));
            if (ev_last_chunk) begin
              state_q <= ST_WB;
            end else begin
              boff_q  <= boff_q + addr_t'(1);
              state_q <= ST_BRD;
            end
          end
        end
        ST_WB:  state_q <= ST_CMP;
        ST_CMP: begin
          cur_q   <= nxt_q;
          wi_q    <= 2'd0;
          state_q <= ST_RDW;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_RDW:  mem_addr = cur_q + addr_t'(wi_q);
      ST_BRD:  mem_addr = buf_q + boff_q;
      ST_WB:   mem_addr = cur_q;
      default: mem_addr = '0;
    endcase
  end

  assign mem_rd     = (state_q == ST_RDW) || (state_q == ST_BRD);
  assign mem_wr     = (state_q == ST_WB);
  assign mem_wdata  = status_word;
  assign cmpl_pulse = (state_q == ST_CMP);
  assign cmpl_irq   = (state_q == ST_CMP) && ic_q;
  assign suspended  = (state_q == ST_SUSP);
endmodule

// File: rtl/txd_ring_dma_chk.sv
`timescale 1ns/1ps
module txd_ring_dma_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       cfg_sel,
  input logic       poll_bit,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       wb_own,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       cmpl_pulse,
  input logic       cmpl_irq,
  input logic       suspended
);
  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!mem_rd && !mem_wr && !tx_valid)); // R3
  AST_SUSP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !(cfg_wr && cfg_sel && poll_bit)) |=> suspended); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R5
  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !wb_own); // R6
  AST_NO_TX_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !tx_valid); // R4
  AST_PULSE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> cmpl_pulse); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_pulse |=> !cmpl_pulse); // R7
  AST_IRQ_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_irq |-> cmpl_pulse); // R7
endmodule

bind txd_ring_dma txd_ring_dma_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_sel    (cfg_sel),
  .poll_bit   (cfg_wdata[0]),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .wb_own     (mem_wdata[31]),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_last    (tx_last),
  .cmpl_pulse (cmpl_pulse),
  .cmpl_irq   (cmpl_irq),
  .suspended  (suspended)
);

// File: tb/txd_ring_dma_tb_top.sv
`timescale 1ns/1ps
module txd_ring_dma_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, cmpl_pulse, cmpl_irq, suspended;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic [3:0]  mac_fault = '0;
  logic [31:0] mem [0:1023];

  txd_ring_dma dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .mac_fault(mac_fault), .cmpl_pulse(cmpl_pulse),
    .cmpl_irq(cmpl_irq), .suspended(suspended));

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  byte unsigned got_b[$], exp_b[$];
  bit           got_l[$], exp_l[$];
  int           wb_addr[$];
  logic [31:0]  wb_val[$];
  logic [3:0]   fpat [0:511];
  int           fat  [0:511];
  int bsf = 0, sfn = 0, bif = 0, rdy_pct = 100;
  int npulse = 0, nirq = 0, n_own_exp = 0, n_ic_exp = 0;
  bit prev_stall = 0, prev_wr = 0, prev_pulse = 0, prev_last = 0;
  logic [7:0] prev_data = '0;

  // Port monitor: drives the sink side, then samples mid-cycle.
  always @(negedge clk) begin
    tx_ready = ($urandom_range(99) < rdy_pct);
    if (!tx_ready) mac_fault = 4'($urandom);
    else           mac_fault = (bif == fat[sfn]) ? fpat[sfn] : 4'h0;
    #1;
    if (rst_n) begin
      if (prev_stall)
        chk(tx_valid && tx_data == prev_data && tx_last == prev_last,
            "R5", "stalled byte changed", tx_data, prev_data);
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_last  = tx_last;
      if (tx_valid && tx_ready) begin
        got_b.push_back(tx_data);
        got_l.push_back(tx_last);
        if (tx_last) begin sfn++; bif = 0; end
        else bif++;
      end
      if (cmpl_pulse) begin
        npulse++;
        if (!prev_wr || prev_pulse)
          chk(0, "R7", "pulse not one cycle after write-back", prev_wr, 1);
      end
      if (cmpl_irq) begin
        nirq++;
        if (!cmpl_pulse) chk(0, "R7", "irq without pulse", 0, 1);
      end
      prev_wr    = mem_wr;
      prev_pulse = cmpl_pulse;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] exp_status(input logic [3:0] p);
    int v = 0;
    if (p[0]) v += 2;
    if (p[1]) v += 256;
    if (p[2]) v += 512;
    if (p[3]) v += 16384;
    if (p != 4'h0) v += 32768;
    return 32'(v);
  endfunction

  task automatic cfg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic put_desc(input int da, input int len, input bit own, input bit ic,
                          input int bufa, input int nxt, input bit faulty);
    logic [31:0] st;
    logic [3:0]  p;
    mem[da+1] = (ic ? 32'h8000_0000 : 32'h0) | ($urandom & 32'h7FFF_F800) | 32'(len);
    mem[da+2] = 32'(bufa);
    mem[da+3] = 32'(nxt);
    mem[da]   = own ? 32'h8000_0000 : 32'h0000_5A5A;
    if (own) begin
      if (len == 0) st = 32'h0;
      else if (len > 1514) st = 32'h0000_C000;
      else begin
        p = faulty ? 4'($urandom_range(15, 1)) : 4'h0;
        fpat[bsf] = p;
        fat[bsf]  = $urandom_range(len - 1);
        bsf++;
        for (int j = 0; j < len; j++) begin
          byte unsigned b;
          b = 8'($urandom);
          mem[bufa + j/4][8*(j%4) +: 8] = b;
          exp_b.push_back(b);
          exp_l.push_back(j == len - 1);
        end
        st = exp_status(p);
      end
      wb_addr.push_back(da);
      wb_val.push_back(st);
      n_own_exp++;
      if (ic) n_ic_exp++;
    end
  endtask

  task automatic wait_susp();
    int n = 0;
    @(negedge clk); @(negedge clk);
    while (!suspended && n < 20000) begin @(negedge clk); n++; end
    chk(suspended, "R3", "engine did not suspend", suspended, 1);
  endtask

  task automatic verify();
    int bad = 0, badl = 0;
    chk(got_b.size() == exp_b.size(), "R4", "byte count", got_b.size(), exp_b.size());
    for (int i = 0; i < got_b.size() && i < exp_b.size(); i++) begin
      if (got_b[i] != exp_b[i]) bad++;
      if (got_l[i] != exp_l[i]) badl++;
    end
    chk(bad == 0, "R4", "byte mismatches", bad, 0);
    chk(badl == 0, "R4", "tx_last misplaced", badl, 0);
    for (int k = 0; k < wb_addr.size(); k++)
      chk(mem[wb_addr[k]] === wb_val[k], "R6", "status write-back", mem[wb_addr[k]], wb_val[k]);
    chk(npulse == n_own_exp, "R7", "completion pulses", npulse, n_own_exp);
    chk(nirq == n_ic_exp, "R7", "irq pulses", nirq, n_ic_exp);
    got_b.delete(); got_l.delete(); exp_b.delete(); exp_l.delete();
    wb_addr.delete(); wb_val.delete();
    npulse = 0; nirq = 0; n_own_exp = 0; n_ic_exp = 0;
  endtask

  initial begin
    logic [31:0] keep;
    void'($urandom(32'h0005_EED1));
    for (int i = 0; i < 512; i++) begin fpat[i] = 4'h0; fat[i] = -1; end
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid, "R1", "tx_valid after reset", tx_valid, 0);
    chk(!mem_rd && !mem_wr, "R1", "memory idle after reset", {mem_rd, mem_wr}, 0);
    chk(!cmpl_pulse && !suspended, "R1", "pulse/suspend after reset", {cmpl_pulse, suspended}, 0);
    repeat (10) @(negedge clk);
    chk(!mem_rd && got_b.size() == 0, "R1", "stays idle without poll", mem_rd, 0);

    // Directed ring: short lengths, zero length, oversize, wrap (R9 R10 R8 R11)
    rdy_pct = 60;
    put_desc(0,  1,    1, 1, 128, 4,  1);
    put_desc(4,  4,    1, 0, 192, 8,  0);
    put_desc(8,  0,    1, 0, 256, 12, 0);
    put_desc(12, 5,    1, 0, 320, 16, 1);
    put_desc(16, 1515, 1, 1, 384, 20, 0);
    put_desc(20, 7,    1, 0, 448, 0,  1);
    cfg(1'b0, 32'd0);
    cfg(1'b1, 32'd1);
    wait_susp();
    chk(mem[8] == 32'h0, "R9", "zero-length status", mem[8], 0);
    chk(mem[16] == 32'h0000_C000, "R10", "oversize status", mem[16], 32'hC000);
    verify();

    // Poll with bit 0 clear is ignored (R2)
    cfg(1'b1, 32'd0);
    repeat (20) @(negedge clk);
    chk(suspended && npulse == 0 && !mem_rd, "R2", "poll without bit 0 acted", suspended, 1);

    // Re-arm the wrapped descriptor: same address fetched again (R3 R8)
    keep = mem[4];
    put_desc(0, 3, 1, 0, 128, 4, 1);
    cfg(1'b1, 32'd1);
    wait_susp();
    chk(mem[4] == keep, "R3", "unowned descriptor was written", mem[4], keep);
    verify();

    // Random rings with busy-time address writes (R2 R4 R5 R6 R7 R8 R11)
    for (int r = 0; r < 8; r++) begin
      int base, k;
      base = (r % 2) ? 64 : 0;
      k = $urandom_range(6, 2);
      rdy_pct = $urandom_range(100, 30);
      for (int i = 0; i < k; i++)
        put_desc(base + 4*i, $urandom_range(60, 1), 1, 1'($urandom), 128 + 64*i,
                 (i == k - 1) ? base : base + 4*(i + 1), ($urandom_range(2) == 0));
      cfg(1'b0, 32'(base));
      cfg(1'b1, 32'd1);
      repeat (3) @(negedge clk);
      cfg(1'b0, 32'h3FF);
      wait_susp();
      verify();
      chk(mem[base] != 32'h0000_5A5A, "R2", "ring ran from loaded base", mem[base], 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule